// File: doc/BRIEF.md
# Chip-Array Word Memory with Two-Phase Addressing

This block builds a wide, deep word memory out of a two-dimensional grid of one-bit-wide square sub-memories. The grid has one column of sub-memories per data bit and one row of sub-memories per slice of the address space. The most significant address bits are decoded into a one-hot group select, so exactly one row of sub-memories takes part in an access. Each sub-memory of that row contributes one bit of the word. The remaining address bits are split into an in-array row half and an in-array column half, and these two halves travel one after the other over a single shared bus. A row strobe marks the first phase and a column strobe marks the second.

A client offers one request at a time through a ready/valid handshake. A request is a read or a write of one full word. Once a request is accepted, the block walks through a row phase, a column phase and a data phase, and then it takes the next request. Read data is registered and is marked by a single-cycle valid pulse. The sizes are parameters. With the group select at 4 bits, the half address at 9 bits and the data at 32 bits, the grid is 16 rows of 32 sub-memories, each 512 x 512. The default values are much smaller so that elaboration stays cheap.

Top module: `chip_mem_array`

## Requirements
- R1: While reset is held and in the first cycle after it, req_ready is 1, and rd_valid, row_strobe, col_strobe, chip_we and chip_sel are all 0.
- R2: In the cycle after a request is accepted (req_valid and req_ready both high at a rising edge), row_strobe is 1 and col_strobe is 0. In that cycle mux_addr carries address bits [2*CHIP_AW-1:CHIP_AW], and chip_sel has exactly bit N set, where N is the value of address bits [ADDR_W-1:2*CHIP_AW].
- R3: In the cycle after that, col_strobe is 1 and row_strobe is 0. mux_addr carries address bits [CHIP_AW-1:0], chip_sel keeps the same single bit, and chip_we is 1 exactly when the request is a write.
- R4: chip_sel never has more than one bit set. It is all zero in every cycle in which neither row_strobe nor col_strobe is high.
- R5: req_ready is 0 in the three cycles that follow acceptance and is 1 again in the fourth. A request offered while req_ready is 0 is ignored and does not change the stored contents.
- R6: For a read, rd_valid is high for exactly one cycle: the fourth cycle after the acceptance edge. In that cycle rd_data holds the word most recently written to that address.
- R7: A write never raises rd_valid. It stores all DATA_W bits of req_wdata at the addressed word.
- R8: An access changes only the sub-memory row picked by the group-select bits. Words that share the in-array address but lie in other rows keep their contents.
- R9: chip_we is only ever high while col_strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write word |
| rd_valid | output | 1 | Single-cycle read data qualifier |
| rd_data | output | DATA_W | Registered read word |
| mux_addr | output | CHIP_AW | Shared in-array address bus |
| row_strobe | output | 1 | Row phase marker on the shared bus |
| col_strobe | output | 1 | Column phase marker on the shared bus |
| chip_we | output | 1 | Write enable given with the column phase |
| chip_sel | output | ROWS | One-hot sub-memory row select |

## Verification
The hardest case to reach from the ports is a request that is offered while the block is busy and must leave no trace. The stimulus holds req_valid high during the busy cycles of every access, with an inverted address, inverted data and the opposite operation. Later reads of those inverted addresses show whether a stray write got in. Isolation between sub-memory rows is forced by directed pairs of writes that share the in-array address but differ in the group-select bits, each followed by read-back. The whole array is filled first, so that every random read has a known expected word.

// File: rtl/cam_pkg.sv
package cam_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ROW  = 2'd1,
    ST_COL  = 2'd2,
    ST_DATA = 2'd3
  } seq_state_t;
endpackage

// File: rtl/cam_row_decoder.sv
module cam_row_decoder #(
  parameter int SEL_W = 2,
  localparam int ROWS = 1 << SEL_W
) (
  input  logic [SEL_W-1:0] sel_code,
  output logic [ROWS-1:0]  sel_onehot
);
  always_comb begin
    sel_onehot = '0;
    for (int i = 0; i < ROWS; i++) begin
      if (sel_code == SEL_W'(i)) sel_onehot[i] = 1'b1;
    end
  end
endmodule

// File: rtl/cam_sequencer.sv
module cam_sequencer
  import cam_pkg::*;
#(
  parameter int ROW_SEL_W = 2,
  parameter int CHIP_AW   = 3,
  parameter int DATA_W    = 8,
  localparam int ROWS     = 1 << ROW_SEL_W,
  localparam int ADDR_W   = ROW_SEL_W + 2 * CHIP_AW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [ROWS-1:0]   dec_onehot,
  output logic              req_ready,
  output logic [CHIP_AW-1:0] mux_addr,
  output logic              row_strobe,
  output logic              col_strobe,
  output logic              chip_we,
  output logic [ROWS-1:0]   chip_sel,
  output logic [DATA_W-1:0] wdata_q,
  output logic              rd_en
);
  seq_state_t state;
  logic [CHIP_AW-1:0] col_q;
  logic               write_q;

  assign req_ready = (state == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      col_q      <= '0;
      write_q    <= 1'b0;
      wdata_q    <= '0;
      mux_addr   <= '0;
      row_strobe <= 1'b0;
      col_strobe <= 1'b0;
      chip_we    <= 1'b0;
      chip_sel   <= '0;
      rd_en      <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          rd_en <= 1'b0;
          if (req_valid) begin
            col_q      <= req_addr[CHIP_AW-1:0];
            write_q    <= req_write;
            wdata_q    <= req_wdata;
            mux_addr   <= req_addr[2*CHIP_AW-1:CHIP_AW];
            row_strobe <= 1'b1;
            chip_sel   <= dec_onehot;
            state      <= ST_ROW;
          end
        end
        ST_ROW: begin
          row_strobe <= 1'b0;
          col_strobe <= 1'b1;
          chip_we    <= write_q;
          mux_addr   <= col_q;
          state      <= ST_COL;
        end
        ST_COL: begin
          col_strobe <= 1'b0;
          chip_we    <= 1'b0;
          chip_sel   <= '0;
          mux_addr   <= '0;
          rd_en      <= ~write_q;
          state      <= ST_DATA;
        end
        default: begin
          rd_en <= 1'b0;
          state <= ST_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/cam_bit_chip.sv
module cam_bit_chip #(
  parameter int CHIP_AW = 3,
  localparam int DEPTH  = 1 << (2 * CHIP_AW)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sel,
  input  logic               row_strobe,
  input  logic               col_strobe,
  input  logic               we,
  input  logic [CHIP_AW-1:0] addr,
  input  logic               din,
  output logic               dout,
  output logic               oe
);
  logic               cells [0:DEPTH-1];
  logic [CHIP_AW-1:0] row_q;

  always_ff @(posedge clk) begin
    if (sel && row_strobe) row_q <= addr;
  end

  always_ff @(posedge clk) begin
    if (sel && col_strobe) begin
      if (we) cells[{row_q, addr}] <= din;
      else    dout <= cells[{row_q, addr}];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) oe <= 1'b0;
    else     oe <= sel && col_strobe && !we;
  end
endmodule

// File: rtl/cam_read_gather.sv
module cam_read_gather #(
  parameter int ROWS   = 4,
  parameter int DATA_W = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         rd_en,
  input  logic [ROWS-1:0][DATA_W-1:0]  chip_dout,
  input  logic [ROWS-1:0]              chip_oe,
  output logic                         rd_valid,
  output logic [DATA_W-1:0]            rd_data
);
  logic [DATA_W-1:0] bus_word;

  always_comb begin
    bus_word = '0;
    for (int r = 0; r < ROWS; r++) begin
      if (chip_oe[r]) bus_word = bus_word | chip_dout[r];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= bus_word;
    end
  end
endmodule

// File: rtl/chip_mem_array.sv
module chip_mem_array #(
  parameter int ROW_SEL_W = 2,
  parameter int CHIP_AW   = 3,
  parameter int DATA_W    = 8,
  localparam int ROWS     = 1 << ROW_SEL_W,
  localparam int ADDR_W   = ROW_SEL_W + 2 * CHIP_AW
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [DATA_W-1:0]  req_wdata,
  output logic               rd_valid,
  output logic [DATA_W-1:0]  rd_data,
  output logic [CHIP_AW-1:0] mux_addr,
  output logic               row_strobe,
  output logic               col_strobe,
  output logic               chip_we,
  output logic [ROWS-1:0]    chip_sel
);
  logic [ROWS-1:0]             dec_onehot;
  logic [DATA_W-1:0]           wdata_q;
  logic                        rd_en;
  logic [ROWS-1:0][DATA_W-1:0] chip_dout;
  logic [ROWS-1:0][DATA_W-1:0] chip_oe_bits;
  logic [ROWS-1:0]             row_oe;

  cam_row_decoder #(.SEL_W(ROW_SEL_W)) u_dec (
    .sel_code  (req_addr[ADDR_W-1:2*CHIP_AW]),
    .sel_onehot(dec_onehot)
  );

  cam_sequencer #(.ROW_SEL_W(ROW_SEL_W), .CHIP_AW(CHIP_AW), .DATA_W(DATA_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .dec_onehot(dec_onehot),
    .req_ready (req_ready),
    .mux_addr  (mux_addr),
    .row_strobe(row_strobe),
    .col_strobe(col_strobe),
    .chip_we   (chip_we),
    .chip_sel  (chip_sel),
    .wdata_q   (wdata_q),
    .rd_en     (rd_en)
  );

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
      cam_bit_chip #(.CHIP_AW(CHIP_AW)) u_chip (
        .clk       (clk),
        .rst       (rst),
        .sel       (chip_sel[r]),
        .row_strobe(row_strobe),
        .col_strobe(col_strobe),
        .we        (chip_we),
        .addr      (mux_addr),
        .din       (wdata_q[b]),
        .dout      (chip_dout[r][b]),
        .oe        (chip_oe_bits[r][b])
      );
    end
    assign row_oe[r] = chip_oe_bits[r][0];
  end

  cam_read_gather #(.ROWS(ROWS), .DATA_W(DATA_W)) u_gather (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (rd_en),
    .chip_dout(chip_dout),
    .chip_oe  (row_oe),
    .rd_valid (rd_valid),
    .rd_data  (rd_data)
  );
endmodule

// File: rtl/cam_checker.sv
module cam_checker #(
  parameter int ROWS    = 4,
  parameter int CHIP_AW = 3
) (
  input logic            clk,
  input logic            rst,
  input logic            req_valid,
  input logic            req_ready,
  input logic            rd_valid,
  input logic            row_strobe,
  input logic            col_strobe,
  input logic            chip_we,
  input logic [ROWS-1:0] chip_sel
);
  a_r4_sel_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(chip_sel));
  a_r4_sel_idle: assert property (@(posedge clk) disable iff (rst)
    (!row_strobe && !col_strobe) |-> (chip_sel == '0));
  a_r2_row_after_accept: assert property (@(posedge clk) disable iff (rst)
    row_strobe |-> $past(req_valid && req_ready));
  a_r3_col_after_row: assert property (@(posedge clk) disable iff (rst)
    row_strobe |=> (col_strobe && !row_strobe));
  a_r3_sel_held: assert property (@(posedge clk) disable iff (rst)
    col_strobe |-> ($stable(chip_sel) && $countones(chip_sel) == 1));
  a_r9_we_in_col: assert property (@(posedge clk) disable iff (rst)
    chip_we |-> col_strobe);
  a_r6_valid_pulse: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid);
  a_r5_busy_during_row: assert property (@(posedge clk) disable iff (rst)
    (row_strobe || col_strobe) |-> !req_ready);
endmodule

bind chip_mem_array cam_checker #(.ROWS(ROWS), .CHIP_AW(CHIP_AW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rd_valid  (rd_valid),
  .row_strobe(row_strobe),
  .col_strobe(col_strobe),
  .chip_we   (chip_we),
  .chip_sel  (chip_sel)
);

// File: tb/sim_chip_mem_array.sv
module sim_chip_mem_array;
  localparam int CLK_PERIOD = 10;
  localparam int SW = 2;
  localparam int CAW = 3;
  localparam int DW = 8;
  localparam int AW = SW + 2 * CAW;
  localparam int NR = 1 << SW;
  localparam int WORDS = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic req_ready;
  logic req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic rd_valid;
  logic [DW-1:0] rd_data;
  logic [CAW-1:0] mux_addr;
  logic row_strobe, col_strobe, chip_we;
  logic [NR-1:0] chip_sel;

  int total = 0;
  int bad = 0;
  logic [DW-1:0] model [0:WORDS-1];

  always #(CLK_PERIOD/2) clk = ~clk;

  chip_mem_array #(.ROW_SEL_W(SW), .CHIP_AW(CAW), .DATA_W(DW)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .mux_addr(mux_addr),
    .row_strobe(row_strobe), .col_strobe(col_strobe), .chip_we(chip_we),
    .chip_sel(chip_sel)
  );

  function automatic logic [DW-1:0] fill_word(input int a);
    return DW'(a * 37 + 5);
  endfunction

  function automatic logic [NR-1:0] exp_sel(input logic [AW-1:0] a);
    return NR'(1) << a[AW-1:2*CAW];
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic op(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    chk(rd_valid == 1'b0, "R6", 32'(rd_valid), 0);
    chk(req_ready == 1'b1, "R5", 32'(req_ready), 1);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_write = ~wr; req_addr = ~a; req_wdata = ~d;
    chk(row_strobe && !col_strobe, "R2", {row_strobe, col_strobe}, 2);
    chk(mux_addr == a[2*CAW-1:CAW], "R2", 32'(mux_addr), 32'(a[2*CAW-1:CAW]));
    chk(chip_sel == exp_sel(a), "R2", 32'(chip_sel), 32'(exp_sel(a)));
    chk(req_ready == 1'b0, "R5", 32'(req_ready), 0);
    @(negedge clk);
    chk(col_strobe && !row_strobe, "R3", {row_strobe, col_strobe}, 1);
    chk(mux_addr == a[CAW-1:0], "R3", 32'(mux_addr), 32'(a[CAW-1:0]));
    chk(chip_sel == exp_sel(a), "R3", 32'(chip_sel), 32'(exp_sel(a)));
    chk(chip_we == wr, "R3", 32'(chip_we), 32'(wr));
    @(negedge clk);
    req_valid = 1'b0;
    chk(chip_sel == '0 && !chip_we, "R4", 32'(chip_sel), 0);
    chk(req_ready == 1'b0, "R5", 32'(req_ready), 0);
    @(negedge clk);
    chk(req_ready == 1'b1, "R5", 32'(req_ready), 1);
    if (wr) begin
      chk(rd_valid == 1'b0, "R7", 32'(rd_valid), 0);
      model[a] = d;
    end else begin
      chk(rd_valid == 1'b1, "R6", 32'(rd_valid), 1);
      chk(rd_data == model[a], "R6", 32'(rd_data), 32'(model[a]));
    end
  endtask

  initial begin
    repeat (CLK_PERIOD * 20000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd29);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(req_ready && !rd_valid, "R1", {req_ready, rd_valid}, 2);
    chk(!row_strobe && !col_strobe && !chip_we && chip_sel == '0, "R1", 32'(chip_sel), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready && !rd_valid && chip_sel == '0, "R1", {req_ready, rd_valid}, 2);
    // R7: fill every word with a known pattern
    for (int i = 0; i < WORDS; i++) op(1'b1, AW'(i), fill_word(i));
    op(1'b0, '0, '0);
    op(1'b0, '1, '0);
    // R8: same in-array address, different sub-memory rows
    for (int r = 0; r < NR; r++) op(1'b1, {SW'(r), 6'h2d}, DW'(8'h11 * (r + 1)));
    for (int r = 0; r < NR; r++) op(1'b0, {SW'(r), 6'h2d}, '0);
    op(1'b1, {SW'(1), 6'h00}, '1);
    op(1'b0, {SW'(0), 6'h00}, '0);
    op(1'b0, {SW'(2), 6'h00}, '0);
    op(1'b0, {SW'(1), 6'h00}, '0);
    // random mix; stray busy-time requests checked through later reads (R5)
    for (int k = 0; k < 600; k++) begin
      logic [AW-1:0] a;
      a = AW'($urandom);
      op(1'($urandom), a, DW'($urandom));
    end
    for (int i = 0; i < WORDS; i++) op(1'b0, AW'(i), '0);
    @(negedge clk);
    chk(rd_valid == 1'b0, "R6", 32'(rd_valid), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule